// File: doc/BRIEF.md
# POCSAG Codeword Error Corrector

This block repairs one received 32-bit paging codeword at a time. A codeword carries, in transmission order, a type flag (0 = address, 1 = message), a 20-bit information field, 10 check bits of a BCH(31,21) code, and an even parity bit over all 32 bits. The block takes the raw word and a burst-enable bit on a one-cycle start pulse. It computes the BCH syndrome of the first 31 bits and the overall parity. It then scans every bit position for a single-error, double-error or short-burst explanation. After a fixed number of clocks it returns the repaired word, the type flag and a 3-bit classification of what it found.

On the port `cw_i[31]` holds transmitted bit 1 (the flag) and `cw_i[0]` holds bit 32 (parity). `cw_i[30:21]` and `cw_i[20:11]` together form the information field, `cw_i[10:1]` the check bits. The check polynomial is x^10+x^9+x^8+x^6+x^5+x^3+1, with `cw_i[1]` as the coefficient of x^0 and `cw_i[31]` as the coefficient of x^30. Sync-word and idle-word matching and address comparison belong to neighbouring blocks.

Top module: `pocsag_corrector`

## Requirements
- R1: A word whose syndrome is zero and whose 32 bits have even parity is returned unchanged with code 000. The code 100 is never produced.
- R2: A word whose syndrome is zero but whose parity is odd is returned with `cw_o[0]` inverted and code 001.
- R3: One wrong bit among `cw_i[31:1]` is repaired and reported as code 010.
- R4: One wrong bit among `cw_i[31:1]` together with a wrong `cw_i[0]` has both bits repaired and is reported as code 011.
- R5: Two wrong bits among `cw_i[31:1]` are repaired and reported as code 110.
- R6: With `burst_en_i` high at start, exactly three wrong bits that all lie within four adjacent positions of `cw_i[31:1]` are repaired and reported as code 101.
- R7: With `burst_en_i` low at start, the same three-bit burst is reported as code 111 and the word is returned as received.
- R8: With `burst_en_i` high, one or two wrong bits are still reported as 010, 011 or 110. The random-error explanation wins over a burst.
- R9: A pattern with no single, double or enabled burst explanation (for example three scattered wrong bits) gives code 111 and the word returned exactly as received.
- R10: `is_msg_o` equals bit 31 of the returned word. A corrupted flag is therefore reported with its repaired value.
- R11: `done_o` is high for exactly one cycle, 32 clocks after the edge that sampled `start_i`. The outputs then hold their values until the next result.
- R12: A `start_i` pulse arriving while a word is being processed is ignored. It neither changes that result nor produces a second `done_o`.
- R13: During and straight after reset, `done_o`, `cw_o`, `err_o` and `is_msg_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accept `cw_i` and `burst_en_i` when idle |
| burst_en_i | input | 1 | Allow three-error burst repair for this word |
| cw_i | input | 32 | Received codeword, transmitted bit 1 in bit 31 |
| done_o | output | 1 | One-cycle pulse marking new results |
| cw_o | output | 32 | Repaired codeword (or raw word when uncorrectable) |
| is_msg_o | output | 1 | Type flag of the returned word, 1 = message |
| err_o | output | 3 | Error classification code |

## Verification
The hardest situation to reach is the one where more than one kind of explanation is in play. Examples are a two-bit adjacent error with burst repair enabled, or a true three-bit burst with burst repair disabled. In these cases only the overall parity and the enable bit keep the result from being miscorrected. The stimulus table builds each case from a clean codeword that the bench encodes itself. It then applies exact error masks: adjacent and distant pairs, all three burst shapes including one touching the flag bit, the same burst with the enable both on and off, and scattered triples. A directed sequence also fires a second start in the middle of a scan.

// File: rtl/pocsag_ecc_pkg.sv
package pocsag_ecc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_FINISH
   } scan_state_e;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'b000,
      ERR_PAR     = 3'b001,
      ERR_ONE     = 3'b010,
      ERR_ONE_PAR = 3'b011,
      ERR_BURST   = 3'b101,
      ERR_TWO     = 3'b110,
      ERR_FAIL    = 3'b111
   } err_code_e;

endpackage

// File: rtl/pcw_syn_table.sv
// Syndrome of every single-bit position: x^k mod g(x), k = 0 .. CODE_N-1.
module pcw_syn_table #(
   parameter int                CODE_N   = 31,
   parameter int                CHK_W    = 10,
   parameter logic [CHK_W:0]    GEN_POLY = 11'h769
) (
   output logic [CODE_N-1:0][CHK_W-1:0] tab_o
);

   always_comb begin
      logic [CHK_W-1:0] rem;
      rem = CHK_W'(1);
      for (int k = 0; k < CODE_N; k++) begin
         tab_o[k] = rem;
         if (rem[CHK_W-1])
            rem = {rem[CHK_W-2:0], 1'b0} ^ GEN_POLY[CHK_W-1:0];
         else
            rem = {rem[CHK_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/pcw_syndrome.sv
// Syndrome of a code vector as the XOR of the per-position syndromes.
module pcw_syndrome #(
   parameter int CODE_N = 31,
   parameter int CHK_W  = 10
) (
   input  logic [CODE_N-1:0]            vec_i,
   input  logic [CODE_N-1:0][CHK_W-1:0] tab_i,
   output logic [CHK_W-1:0]             syn_o
);

   always_comb begin
      syn_o = '0;
      for (int k = 0; k < CODE_N; k++)
         if (vec_i[k]) syn_o = syn_o ^ tab_i[k];
   end

endmodule

// File: rtl/pcw_candidate.sv
// Tests, for one anchor position, the single, pair and burst hypotheses.
module pcw_candidate #(
   parameter int CODE_N        = 31,
   parameter int CHK_W         = 10,
   parameter int BURST_SPAN    = 4,
   parameter bit BURST_SUPPORT = 1'b1
) (
   input  logic [CHK_W-1:0]             syn_i,
   input  logic [CODE_N-1:0][CHK_W-1:0] tab_i,
   input  logic [$clog2(CODE_N)-1:0]    idx_i,
   output logic                         single_hit_o,
   output logic                         double_hit_o,
   output logic [CODE_N-1:0]            double_mask_o,
   output logic                         burst_hit_o,
   output logic [CODE_N-1:0]            burst_mask_o
);

   localparam int IDXW      = $clog2(CODE_N);
   localparam int BURST_ERR = 3;

   logic [CHK_W-1:0] base_syn;
   logic [CHK_W-1:0] rest_syn;

   assign base_syn     = tab_i[idx_i];
   assign rest_syn     = syn_i ^ base_syn;
   assign single_hit_o = (syn_i == base_syn);

   // partner position above the anchor whose syndrome completes the pair
   always_comb begin
      logic found;
      found         = 1'b0;
      double_mask_o = '0;
      for (int j = 0; j < CODE_N; j++) begin
         if (!found && (j > int'(idx_i)) && (tab_i[j] == rest_syn)) begin
            found            = 1'b1;
            double_mask_o[j] = 1'b1;
         end
      end
      if (found) double_mask_o[idx_i] = 1'b1;
      double_hit_o = found;
   end

   generate
      if (BURST_SUPPORT) begin : g_burst
         logic                hit_w;
         logic [CODE_N-1:0]   mask_w;

         always_comb begin
            logic [CHK_W-1:0]  acc;
            logic              fits;
            logic [CODE_N-1:0] m;
            hit_w  = 1'b0;
            mask_w = '0;
            for (int p = 1; p < (1 << BURST_SPAN); p++) begin
               acc  = '0;
               fits = 1'b1;
               m    = '0;
               if (p[0] && ($countones(p) == BURST_ERR)) begin
                  for (int o = 0; o < BURST_SPAN; o++) begin
                     if (p[o]) begin
                        if (int'(idx_i) + o >= CODE_N) begin
                           fits = 1'b0;
                        end else begin
                           acc = acc ^ tab_i[IDXW'(int'(idx_i) + o)];
                           m[IDXW'(int'(idx_i) + o)] = 1'b1;
                        end
                     end
                  end
                  if (fits && !hit_w && (acc == syn_i)) begin
                     hit_w  = 1'b1;
                     mask_w = m;
                  end
               end
            end
         end

         assign burst_hit_o  = hit_w;
         assign burst_mask_o = mask_w;
      end else begin : g_no_burst
         assign burst_hit_o  = 1'b0;
         assign burst_mask_o = '0;
      end
   endgenerate

endmodule

// File: rtl/pocsag_corrector.sv
module pocsag_corrector
   import pocsag_ecc_pkg::*;
#(
   parameter int             CODE_N        = 31,
   parameter int             CHK_W         = 10,
   parameter logic [CHK_W:0] GEN_POLY      = 11'h769,
   parameter int             BURST_SPAN    = 4,
   parameter bit             BURST_SUPPORT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              burst_en_i,
   input  logic [CODE_N:0]   cw_i,
   output logic              done_o,
   output logic [CODE_N:0]   cw_o,
   output logic              is_msg_o,
   output logic [2:0]        err_o
);

   localparam int IDXW = $clog2(CODE_N);
   localparam int LAT  = CODE_N + 1;
   localparam int CNTW = $clog2(LAT + 2);

   // elaboration-time parameter checks
   generate
      if (CHK_W < 2 || CHK_W >= CODE_N) begin : g_bad_chk
         $error("check width must lie between 2 and CODE_N-1");
      end
      if (!GEN_POLY[CHK_W] || !GEN_POLY[0]) begin : g_bad_poly
         $error("generator needs both end coefficients set");
      end
      if (BURST_SPAN < 3 || BURST_SPAN > CODE_N) begin : g_bad_span
         $error("burst span must be at least 3 and fit the code");
      end
   endgenerate

   scan_state_e                 state_q;
   logic [CODE_N:0]             word_q;
   logic                        ben_q;
   logic [IDXW-1:0]             idx_q;
   logic                        single_q, double_q, burst_q;
   logic [CODE_N-1:0]           single_mask_q, double_mask_q, burst_mask_q;
   logic                        done_q;
   logic [CODE_N:0]             cw_q;
   err_code_e                   err_q;

   logic [CODE_N-1:0][CHK_W-1:0] pos_tab;
   logic [CHK_W-1:0]             in_syn;
   logic                         c_single, c_double, c_burst;
   logic [CODE_N-1:0]            c_double_mask, c_burst_mask;

   pcw_syn_table #(.CODE_N(CODE_N), .CHK_W(CHK_W), .GEN_POLY(GEN_POLY)) u_tab (
      .tab_o (pos_tab)
   );

   pcw_syndrome #(.CODE_N(CODE_N), .CHK_W(CHK_W)) u_syn_in (
      .vec_i (word_q[CODE_N:1]),
      .tab_i (pos_tab),
      .syn_o (in_syn)
   );

   pcw_candidate #(
      .CODE_N(CODE_N), .CHK_W(CHK_W),
      .BURST_SPAN(BURST_SPAN), .BURST_SUPPORT(BURST_SUPPORT)
   ) u_cand (
      .syn_i         (in_syn),
      .tab_i         (pos_tab),
      .idx_i         (idx_q),
      .single_hit_o  (c_single),
      .double_hit_o  (c_double),
      .double_mask_o (c_double_mask),
      .burst_hit_o   (c_burst),
      .burst_mask_o  (c_burst_mask)
   );

   // final classification from the syndrome, overall parity and scan hits
   logic            par_odd;
   logic [CODE_N:0] fix_d;
   err_code_e       err_d;

   always_comb begin
      par_odd = ^word_q;
      fix_d   = '0;
      err_d   = ERR_FAIL;
      if (in_syn == '0) begin
         fix_d[0] = par_odd;
         err_d    = par_odd ? ERR_PAR : ERR_NONE;
      end else if (single_q) begin
         fix_d = {single_mask_q, ~par_odd};
         err_d = par_odd ? ERR_ONE : ERR_ONE_PAR;
      end else if (double_q && !par_odd) begin
         fix_d = {double_mask_q, 1'b0};
         err_d = ERR_TWO;
      end else if (burst_q && par_odd) begin
         fix_d = {burst_mask_q, 1'b0};
         err_d = ERR_BURST;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q       <= ST_IDLE;
         word_q        <= '0;
         ben_q         <= 1'b0;
         idx_q         <= '0;
         single_q      <= 1'b0;
         double_q      <= 1'b0;
         burst_q       <= 1'b0;
         single_mask_q <= '0;
         double_mask_q <= '0;
         burst_mask_q  <= '0;
         done_q        <= 1'b0;
         cw_q          <= '0;
         err_q         <= ERR_NONE;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  word_q   <= cw_i;
                  ben_q    <= burst_en_i;
                  idx_q    <= '0;
                  single_q <= 1'b0;
                  double_q <= 1'b0;
                  burst_q  <= 1'b0;
                  state_q  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (c_single && !single_q) begin
                  single_q      <= 1'b1;
                  single_mask_q <= {{(CODE_N-1){1'b0}}, 1'b1} << idx_q;
               end
               if (c_double && !double_q) begin
                  double_q      <= 1'b1;
                  double_mask_q <= c_double_mask;
               end
               if (ben_q && c_burst && !burst_q) begin
                  burst_q      <= 1'b1;
                  burst_mask_q <= c_burst_mask;
               end
               if (idx_q == IDXW'(CODE_N - 1)) state_q <= ST_FINISH;
               else                            idx_q   <= idx_q + IDXW'(1);
            end
            ST_FINISH: begin
               cw_q    <= word_q ^ fix_d;
               err_q   <= err_d;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done_o   = done_q;
   assign cw_o     = cw_q;
   assign is_msg_o = cw_q[CODE_N];
   assign err_o    = err_q;

   // ---------------- assertions ----------------
   logic [CHK_W-1:0] out_syn;
   logic [CNTW-1:0]  chk_cnt;

   pcw_syndrome #(.CODE_N(CODE_N), .CHK_W(CHK_W)) u_syn_out (
      .vec_i (cw_q[CODE_N:1]),
      .tab_i (pos_tab),
      .syn_o (out_syn)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            chk_cnt <= '1;
      else if (state_q == ST_IDLE && start_i) chk_cnt <= '0;
      else if (chk_cnt != '1)                 chk_cnt <= chk_cnt + CNTW'(1);
   end

   p_no_reserved_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (err_o != 3'b100));

   p_even_output_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o != 3'b111) |-> ((^cw_o) == 1'b0));

   p_valid_output_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o != 3'b111) |-> (out_syn == '0));

   p_burst_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !ben_q) |-> (err_o != 3'b101));

   p_fail_raw_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && err_o == 3'b111) |-> (cw_o == word_q));

   p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (chk_cnt == CNTW'(LAT)));

   p_busy_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != ST_IDLE && start_i) |=> $stable(word_q));

endmodule

// File: tb/pocsag_corrector_test.sv
`timescale 1ns/1ps
module pocsag_corrector_test;

   localparam int NV = 14;

   // clean information (flag + 20 bits), error mask, burst enable, expected code
   localparam logic [20:0] V_INFO [NV] = '{
      21'h0A5A5A, 21'h1FFFFF, 21'h012345, 21'h100F0F, 21'h0ABCDE,
      21'h133333, 21'h055555, 21'h0F0F0F, 21'h1A2B3C, 21'h1A2B3C,
      21'h076543, 21'h1C3C3C, 21'h02468A, 21'h13579B };
   localparam logic [31:0] V_MASK [NV] = '{
      32'h0000_0000,  // R1 clean
      32'h0000_0001,  // R2 parity bit only
      32'h0010_0000,  // R3 single in information field
      32'h8000_0000,  // R3 R10 flag bit flipped
      32'h0000_0003,  // R4 lowest check bit + parity bit
      32'h4000_0004,  // R5 distant pair
      32'h0001_8000,  // R8 adjacent pair, burst enabled
      32'h0000_0800,  // R8 single, burst enabled
      32'h001A_0000,  // R6 burst 1101 shape
      32'h001A_0000,  // R7 same burst, disabled
      32'h0000_0380,  // R6 burst 111 shape
      32'hB000_0000,  // R6 burst 1011 shape at the flag
      32'h4000_8008,  // R9 scattered triple
      32'h0000_0005 };// R4 check bit + parity bit
   localparam bit V_BEN [NV] = '{0,0,0,0,0,0,1,1,1,0,1,1,0,0};
   localparam logic [2:0] V_CODE [NV] = '{
      3'b000, 3'b001, 3'b010, 3'b010, 3'b011, 3'b110, 3'b110,
      3'b010, 3'b101, 3'b111, 3'b101, 3'b101, 3'b111, 3'b011 };
   localparam string V_REQ [NV] = '{
      "R1", "R2", "R3", "R10", "R4", "R5", "R8",
      "R8", "R6", "R7", "R6", "R6", "R9", "R4" };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ben_in = 1'b0;
   logic [31:0] cw_in = '0;
   logic        done;
   logic [31:0] cw_out;
   logic        is_msg;
   logic [2:0]  err;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pocsag_corrector uut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .burst_en_i (ben_in),
      .cw_i       (cw_in),
      .done_o     (done),
      .cw_o       (cw_out),
      .is_msg_o   (is_msg),
      .err_o      (err)
   );

   function automatic logic [31:0] encode(input logic [20:0] info);
      logic [9:0] r;
      logic       fb;
      r = '0;
      for (int i = 20; i >= 0; i--) begin
         fb = info[i] ^ r[9];
         r  = {r[8:0], 1'b0};
         if (fb) r = r ^ 10'h369;
      end
      return {info, r, ^{info, r}};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic launch(input logic [31:0] w, input bit b);
      @(negedge clk);
      cw_in  = w;
      ben_in = b;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      while (lat < 40) begin
         @(negedge clk);
         lat++;
         if (done) break;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
   end

   initial begin : main
      int          lat;
      logic [31:0] clean, bad, exp_cw, held;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R13 reset state
      check(done == 1'b0 && err == 3'b000 && is_msg == 1'b0, "R13",
            {28'd0, done, err}, 32'd0);
      check(cw_out == 32'd0, "R13", cw_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && cw_out == 32'd0, "R13", cw_out, 32'd0);

      for (int v = 0; v < NV; v++) begin
         clean  = encode(V_INFO[v]);
         bad    = clean ^ V_MASK[v];
         exp_cw = (V_CODE[v] == 3'b111) ? bad : clean;
         launch(bad, V_BEN[v]);
         wait_done(lat);
         check(lat == 32, "R11", 32'(lat), 32'd32);
         check(err == V_CODE[v], V_REQ[v], {29'd0, err}, {29'd0, V_CODE[v]});
         check(cw_out == exp_cw, V_REQ[v], cw_out, exp_cw);
         check(is_msg == exp_cw[31], "R10", {31'd0, is_msg}, {31'd0, exp_cw[31]});
         held = cw_out;
         @(negedge clk);
         check(done == 1'b0, "R11", {31'd0, done}, 32'd0);
         repeat (3) @(negedge clk);
         check(cw_out == held, "R11", cw_out, held);
      end

      // R12: second start in the middle of a scan is ignored
      clean = encode(21'h0C0FFE);
      bad   = clean ^ 32'h0000_4000;
      launch(bad, 1'b0);
      lat = 0;
      while (lat < 40) begin
         @(negedge clk);
         lat++;
         if (lat == 5) begin
            cw_in = 32'hDEAD_BEEF;
            start = 1'b1;
         end else if (lat == 6) begin
            start = 1'b0;
         end
         if (done) break;
      end
      check(lat == 32, "R12", 32'(lat), 32'd32);
      check(cw_out == clean && err == 3'b010, "R12", cw_out, clean);
      lat = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (done) lat++;
      end
      check(lat == 0, "R12", 32'(lat), 32'd0);

      finish_run();
   end

endmodule